// File: doc/BRIEF.md
# Latching event counter with selectable capture modes

This block is a 16-bit up-counter for measurement hardware. It counts rising edges of an event input, every cycle of its own reference clock, or carry pulses from a lower stage. A power-of-two prescaler sits in front of the counter. The host can load the counter with any starting value. Loading it one count short of wrapping turns the terminal-count pulse into an event holdoff or a timed delay.

The running value is copied into a holding register that the host reads. Three capture modes are available. In the armed mode, an arm request waits for the next counted increment. In the forced mode, a host write captures at once. In the chained mode, the capture strobe comes from a neighbouring counter.

Two instances form a 32-bit pair. The lower stage's terminal-count output feeds the upper stage's carry input. The lower stage's capture pulse feeds the upper stage's chained-capture input. Wrap, capture and overwrite-before-read events raise a one-cycle interrupt pulse, each only when its mask bit is set.

Top module: `evt_latch_counter`

## Requirements
- R1: After reset, count_o, latch_o, latch_valid_o, cap_o, tc_o and irq_o are all zero, and the control register is zero (armed mode, all interrupts masked, prescale exponent 0).
- R2: src_sel_i picks what advances the counter: 00 rising edges of evt_i (a level held high counts once), 01 every clock, 10 each cycle carry_i is high, 11 nothing.
- R3: A cycle with preset_we_i high loads preset_val_i into the counter, wins over any increment in that cycle, and restarts the prescaler.
- R4: Control bits [12:6] hold an exponent e. The counter advances once for every 2^e source ticks.
- R5: When an increment takes the count from all ones to zero, tc_o pulses high for exactly the one cycle in which count_o reads zero.
- R6: Capture mode is control bits [1:0]. In mode 00, an arm_i pulse captures nothing by itself. The first increment at a later edge captures the count as it stands after that increment, and consumes the arm. arm_i has no effect in other modes.
- R7: A control write with mode 01 and bit 2 set captures the count at that edge. Bit 2 is a strobe and is not retained. Bit 2 written with any other mode captures nothing.
- R8: In mode 10, a cycle with casc_latch_i high captures the count as it stands after that edge. In other modes casc_latch_i is ignored.
- R9: cap_o pulses high for one cycle after each capture, together with the new latch_o value.
- R10: latch_valid_o is set by a capture and cleared by rd_i. When a capture and rd_i coincide, the capture wins and the flag stays set.
- R11: Control bits [5:3] are interrupt enables: bit 3 wrap, bit 4 capture, bit 5 overwrite (a capture while latch_valid_o is set and rd_i is low). irq_o pulses for one cycle, together with the event, only if the matching enable is set.
- R12: Two instances chained (upper carry_i from lower tc_o, upper casc_latch_i from lower cap_o, upper in mode 10) capture a consistent 32-bit value across a lower-stage wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the reference count source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 2 | Count source select |
| evt_i | input | 1 | Event input, rising edges counted |
| carry_i | input | 1 | Carry pulse from a lower stage |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 13 | Control write data (mode, force, mask, exponent) |
| preset_we_i | input | 1 | Counter load strobe |
| preset_val_i | input | 16 | Counter load value |
| arm_i | input | 1 | Arm request for the armed capture mode |
| casc_latch_i | input | 1 | Capture strobe from a neighbouring stage |
| rd_i | input | 1 | Host read of latch_o, clears the valid flag |
| count_o | output | 16 | Running count |
| latch_o | output | 16 | Captured count |
| latch_valid_o | output | 1 | Captured value not yet read |
| cap_o | output | 1 | One-cycle pulse after a capture |
| tc_o | output | 1 | One-cycle terminal-count pulse on wrap |
| irq_o | output | 1 | Masked interrupt pulse |

## Verification
The bench builds two instances with the default 16-bit counter and 7-bit exponent field, so the 13-bit control layout is exercised exactly as specified. Presets close to all ones put the wrap within a few cycles, and small exponents show the prescaler's division and its reset by preset within a handful of ticks. The second instance, wired as an upper stage, makes the chained carry and chained capture observable as one 32-bit result.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

  typedef enum logic [1:0] {
    LM_NORMAL  = 2'b00,
    LM_FORCED  = 2'b01,
    LM_CASCADE = 2'b10,
    LM_RSVD    = 2'b11
  } latch_mode_e;

  typedef enum logic [1:0] {
    SRC_EVT   = 2'b00,
    SRC_REF   = 2'b01,
    SRC_CARRY = 2'b10,
    SRC_HOLD  = 2'b11
  } cnt_src_e;

  // control word bit positions
  localparam int unsigned CTL_MODE_LSB = 0;
  localparam int unsigned CTL_FORCE    = 2;
  localparam int unsigned CTL_MASK_LSB = 3;
  localparam int unsigned CTL_MASK_W   = 3;
  localparam int unsigned CTL_EXP_LSB  = 6;

  // interrupt mask bit order
  localparam int unsigned IRQ_WRAP = 0;
  localparam int unsigned IRQ_CAP  = 1;
  localparam int unsigned IRQ_OVF  = 2;

endpackage

// File: rtl/evt_src_sel.sv
module evt_src_sel
  import evt_cnt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cnt_src_e src_i,
  input  logic     evt_i,
  input  logic     carry_i,
  output logic     tick_o
);

  logic evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= evt_i;
  end

  always_comb begin
    unique case (src_i)
      SRC_EVT:   tick_o = evt_i & ~evt_q;
      SRC_REF:   tick_o = 1'b1;
      SRC_CARRY: tick_o = carry_i;
      default:   tick_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int unsigned EXP_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             tick_i,
  output logic             inc_o
);

  localparam int unsigned DIV_W = 1 << EXP_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = (DIV_W'(1) << exp_i) - DIV_W'(1);
  // >= keeps a lowered exponent from stranding the divider above its limit
  assign inc_o = tick_i && (div_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (tick_i) div_q <= inc_o ? '0 : div_q + DIV_W'(1);
  end

  a_r4_div_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |=> div_q == '0);

  a_r3_div_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> div_q == '0);

endmodule

// File: rtl/evt_capture.sv
module evt_capture
  import evt_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  latch_mode_e           mode_i,
  input  logic                  force_i,
  input  logic                  arm_i,
  input  logic                  casc_i,
  input  logic                  inc_i,
  input  logic                  rd_i,
  input  logic                  wrap_i,
  input  logic [CNT_W-1:0]      cnt_nxt_i,
  input  logic [CTL_MASK_W-1:0] mask_i,
  output logic [CNT_W-1:0]      latch_o,
  output logic                  valid_o,
  output logic                  cap_o,
  output logic                  irq_o
);

  logic armed_q;
  logic cap_sync, cap_casc, cap;
  logic ovf;
  logic [CTL_MASK_W-1:0] evt_vec;

  assign cap_sync = (mode_i == LM_NORMAL) && armed_q && inc_i;
  assign cap_casc = (mode_i == LM_CASCADE) && casc_i;
  assign cap      = cap_sync | cap_casc | force_i;
  assign ovf      = cap && valid_o && !rd_i;

  always_comb begin
    evt_vec           = '0;
    evt_vec[IRQ_WRAP] = wrap_i;
    evt_vec[IRQ_CAP]  = cap;
    evt_vec[IRQ_OVF]  = ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      latch_o <= '0;
      valid_o <= 1'b0;
      cap_o   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      armed_q <= (mode_i == LM_NORMAL) && ((armed_q && !inc_i) || arm_i);
      if (cap) latch_o <= cnt_nxt_i;
      valid_o <= cap | (valid_o & ~rd_i);
      cap_o   <= cap;
      irq_o   <= |(evt_vec & mask_i);
    end
  end

  a_r10_valid_fall_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> $past(rd_i));

  a_r9_cap_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> valid_o);

  a_r6_arm_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != LM_NORMAL) |=> !armed_q);

  a_r11_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mask_i != '0));

endmodule

// File: rtl/evt_latch_counter.sv
module evt_latch_counter
  import evt_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 7,
  localparam int unsigned CTL_W = CTL_EXP_LSB + PSC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_sel_i,
  input  logic             evt_i,
  input  logic             carry_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             preset_we_i,
  input  logic [CNT_W-1:0] preset_val_i,
  input  logic             arm_i,
  input  logic             casc_latch_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] latch_o,
  output logic             latch_valid_o,
  output logic             cap_o,
  output logic             tc_o,
  output logic             irq_o
);

  latch_mode_e           mode_q;
  logic [CTL_MASK_W-1:0] mask_q;
  logic [PSC_W-1:0]      exp_q;
  logic                  force_stb;
  logic                  tick, inc, wrap;
  logic [CNT_W-1:0]      cnt_q, cnt_nxt;

  // control register; force bit is a strobe and is not stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= LM_NORMAL;
      mask_q <= '0;
      exp_q  <= '0;
    end else if (ctl_we_i) begin
      mode_q <= latch_mode_e'(ctl_wdata_i[CTL_MODE_LSB +: 2]);
      mask_q <= ctl_wdata_i[CTL_MASK_LSB +: CTL_MASK_W];
      exp_q  <= ctl_wdata_i[CTL_EXP_LSB +: PSC_W];
    end
  end

  assign force_stb = ctl_we_i && ctl_wdata_i[CTL_FORCE] &&
                     (ctl_wdata_i[CTL_MODE_LSB +: 2] == LM_FORCED);

  evt_src_sel i_src (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (cnt_src_e'(src_sel_i)),
    .evt_i   (evt_i),
    .carry_i (carry_i),
    .tick_o  (tick)
  );

  evt_prescaler #(.EXP_W(PSC_W)) i_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (preset_we_i),
    .exp_i  (exp_q),
    .tick_i (tick),
    .inc_o  (inc)
  );

  assign wrap = inc && !preset_we_i && (cnt_q == '1);

  always_comb begin
    if (preset_we_i) cnt_nxt = preset_val_i;
    else if (inc)    cnt_nxt = cnt_q + CNT_W'(1);
    else             cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      tc_o  <= wrap;
    end
  end

  assign count_o = cnt_q;

  evt_capture #(.CNT_W(CNT_W)) i_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_q),
    .force_i   (force_stb),
    .arm_i     (arm_i),
    .casc_i    (casc_latch_i),
    .inc_i     (inc),
    .rd_i      (rd_i),
    .wrap_i    (wrap),
    .cnt_nxt_i (cnt_nxt),
    .mask_i    (mask_q),
    .latch_o   (latch_o),
    .valid_o   (latch_valid_o),
    .cap_o     (cap_o),
    .irq_o     (irq_o)
  );

  a_r5_tc_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> count_o == '0);

  a_r3_preset_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_we_i |=> count_o == $past(preset_val_i));

  a_r2_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == SRC_HOLD && !preset_we_i) |=> $stable(count_o));

  a_r5_tc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o || (count_o == '0 && $past(preset_we_i) == 1'b0 && $past(count_o) == '0) == 1'b0);

endmodule

// File: tb/test_evt_latch_counter.sv
module test_evt_latch_counter;
  import evt_cnt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src = SRC_HOLD;
  logic        evt = 1'b0, ctl_we = 1'b0, preset_we = 1'b0;
  logic        arm = 1'b0, casc = 1'b0, rd = 1'b0;
  logic [12:0] ctl_d = '0;
  logic [15:0] preset_v = '0;
  logic [15:0] count, latch;
  logic        valid, cap, tc, irq;

  logic        u_ctl_we = 1'b0, u_preset_we = 1'b0, u_rd = 1'b0;
  logic [12:0] u_ctl_d = '0;
  logic [15:0] u_preset_v = '0;
  logic [15:0] u_count, u_latch;
  logic        u_valid, u_cap, u_tc, u_irq;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  evt_latch_counter i_evt_latch_counter (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src), .evt_i(evt), .carry_i(1'b0),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_d), .preset_we_i(preset_we),
    .preset_val_i(preset_v), .arm_i(arm), .casc_latch_i(casc), .rd_i(rd),
    .count_o(count), .latch_o(latch), .latch_valid_o(valid), .cap_o(cap),
    .tc_o(tc), .irq_o(irq));

  evt_latch_counter i_upper (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(SRC_CARRY), .evt_i(1'b0), .carry_i(tc),
    .ctl_we_i(u_ctl_we), .ctl_wdata_i(u_ctl_d), .preset_we_i(u_preset_we),
    .preset_val_i(u_preset_v), .arm_i(1'b0), .casc_latch_i(cap), .rd_i(u_rd),
    .count_o(u_count), .latch_o(u_latch), .latch_valid_o(u_valid), .cap_o(u_cap),
    .tc_o(u_tc), .irq_o(u_irq));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic nxt(); @(negedge clk); endtask

  task automatic wr_ctl(input logic [12:0] d);
    ctl_we = 1'b1; ctl_d = d; nxt(); ctl_we = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    preset_we = 1'b1; preset_v = v; nxt(); preset_we = 1'b0;
  endtask

  task automatic pulse_evt();
    evt = 1'b1; nxt(); evt = 1'b0; nxt();
  endtask

  task automatic host_rd();
    rd = 1'b1; nxt(); rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0); chk("R1 latch", latch, 0);
    chk("R1 flags", {valid, cap, tc, irq}, 0);
  endtask

  task automatic t_preset();
    load(16'h1234); chk("R3 load", count, 16'h1234);
    src = SRC_REF; load(16'h0010); chk("R3 preset wins", count, 16'h0010);
    nxt(); src = SRC_HOLD; chk("R3 counts after", count, 16'h0011);
  endtask

  task automatic t_sources();
    load(0); src = SRC_REF;
    for (int i = 0; i < 5; i++) nxt();
    src = SRC_HOLD; chk("R2 ref clock", count, 5);
    load(0); src = SRC_EVT;
    for (int i = 0; i < 3; i++) pulse_evt();
    chk("R2 event edges", count, 3);
    evt = 1'b1; for (int i = 0; i < 4; i++) nxt();
    evt = 1'b0; nxt(); chk("R2 held level once", count, 4);
    src = SRC_HOLD; pulse_evt(); pulse_evt(); chk("R2 hold", count, 4);
  endtask

  task automatic t_carry_src();
    load(0); src = SRC_CARRY;
    force i_evt_latch_counter.carry_i = 1'b1; nxt();
    force i_evt_latch_counter.carry_i = 1'b0; nxt();
    force i_evt_latch_counter.carry_i = 1'b1; nxt();
    release i_evt_latch_counter.carry_i;
    src = SRC_HOLD; chk("R2 carry source", count, 2);
  endtask

  task automatic t_prescale();
    wr_ctl(13'(2 << 6)); load(0); src = SRC_REF;
    for (int i = 0; i < 8; i++) nxt();
    chk("R4 div4 eight ticks", count, 2);
    for (int i = 0; i < 3; i++) nxt();
    chk("R4 div4 partial", count, 2);
    nxt(); src = SRC_HOLD; chk("R4 div4 next", count, 3);
    wr_ctl(0);
  endtask

  task automatic t_wrap(input logic [12:0] c, input logic exp_irq);
    wr_ctl(c); load(16'hFFFE); src = SRC_REF;
    nxt(); chk("R5 pre-wrap", {count, tc}, {16'hFFFF, 1'b0});
    chk("R11 irq pre", irq, 0);
    nxt(); chk("R5 wrap tc", {count, tc}, {16'h0000, 1'b1});
    chk("R11 wrap irq", irq, exp_irq);
    nxt(); src = SRC_HOLD; chk("R5 tc one cycle", {count, tc}, {16'h0001, 1'b0});
    chk("R11 irq one cycle", irq, 0);
  endtask

  task automatic t_normal();
    wr_ctl(0); host_rd(); load(16'd100); src = SRC_HOLD;
    arm = 1'b1; nxt(); arm = 1'b0;
    nxt(); nxt(); chk("R6 arm alone no capture", valid, 0);
    src = SRC_EVT; evt = 1'b1; nxt();
    chk("R6 capture value", latch, 16'd101); chk("R10 valid set", valid, 1);
    chk("R9 cap pulse", cap, 1);
    evt = 1'b0; nxt(); chk("R9 cap one cycle", cap, 0);
    pulse_evt(); chk("R6 arm consumed", {count, latch}, {16'd102, 16'd101});
    host_rd(); chk("R10 read clears", valid, 0);
    src = SRC_HOLD;
  endtask

  task automatic t_forced();
    wr_ctl(13'h001); load(16'h0055); chk("R7 no strobe", valid, 0);
    wr_ctl(13'h005); chk("R7 forced capture", {valid, latch}, {1'b1, 16'h0055});
    chk("R9 forced cap pulse", cap, 1);
    host_rd();
    wr_ctl(13'h004); chk("R7 strobe ignored in mode 00", valid, 0);
    wr_ctl(13'h001); arm = 1'b1; nxt(); arm = 1'b0;
    src = SRC_EVT; pulse_evt(); src = SRC_HOLD;
    chk("R6 arm ignored in mode 01", valid, 0);
    wr_ctl(0); src = SRC_EVT; pulse_evt(); src = SRC_HOLD;
    chk("R6 no stale arm", valid, 0);
  endtask

  task automatic t_casc();
    wr_ctl(13'h002); load(16'h0077);
    casc = 1'b1; nxt(); casc = 1'b0;
    chk("R8 chained capture", {valid, latch}, {1'b1, 16'h0077});
    host_rd(); wr_ctl(0);
    casc = 1'b1; nxt(); casc = 1'b0; nxt();
    chk("R8 strobe ignored", valid, 0);
  endtask

  task automatic t_irq_cap();
    wr_ctl(13'h022);
    casc = 1'b1; nxt(); casc = 1'b0; chk("R11 first capture no overwrite", irq, 0);
    casc = 1'b1; nxt(); casc = 1'b0; chk("R11 overwrite irq", irq, 1);
    nxt(); chk("R11 overwrite one cycle", irq, 0);
    casc = 1'b1; rd = 1'b1; nxt(); casc = 1'b0; rd = 1'b0;
    chk("R10 capture beats read", valid, 1); chk("R11 no overwrite on read", irq, 0);
    host_rd(); wr_ctl(13'h012);
    casc = 1'b1; nxt(); casc = 1'b0; chk("R11 capture irq", irq, 1);
    host_rd(); wr_ctl(0);
  endtask

  task automatic t_chain();
    wr_ctl(0); host_rd();
    u_ctl_we = 1'b1; u_ctl_d = 13'h002; u_rd = 1'b1;
    u_preset_we = 1'b1; u_preset_v = 16'd5; load(16'hFFFF);
    u_ctl_we = 1'b0; u_rd = 1'b0; u_preset_we = 1'b0;
    arm = 1'b1; nxt(); arm = 1'b0;
    src = SRC_REF; nxt(); src = SRC_HOLD;
    chk("R12 lower latch", {valid, latch, tc}, {1'b1, 16'h0000, 1'b1});
    nxt();
    chk("R12 upper count", u_count, 16'd6);
    chk("R12 upper latch", {u_valid, u_latch}, {1'b1, 16'd6});
  endtask

  initial begin
    #35 rst_n = 1'b1;
    nxt();
    t_reset();
    t_preset();
    t_sources();
    t_carry_src();
    t_prescale();
    t_wrap(13'h008, 1'b1);
    t_wrap(13'h000, 1'b0);
    t_normal();
    t_forced();
    t_casc();
    t_irq_cap();
    t_chain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule